// File: doc/BRIEF.md
# Banked Status Register Transfer Unit

This unit keeps the current program status word of a small processor core, along with a bank of saved status words. Each privileged exception mode has its own saved word. The core's execute stage hands it one transfer at a time. A transfer either copies a status word into a general register (a read) or loads a status word from a 32-bit source operand (a write). The source operand is either a register value or an already expanded immediate.

A write may update the whole word or only the four condition flags. In that word the flags sit at bits 31 down to 28, in the order N, Z, C, V. Software running in user mode cannot change the control or mode bits of the current word.

The processor mode is read from bits [4:0] of the current word. That mode decides two things:
- how a write to the current word is masked;
- which saved word a saved-status access reaches.

A separate flag port lets the ALU load the condition flags directly. A status-word write to the current word takes precedence over that port.

Top module: `status_xfer_unit`

## Requirements
- R1: A flags-only write, to either the current or the saved word, copies source bits [31:28] into bits [31:28] of that word. Bits [31:28] are N, Z, C, V from the top down. Bits [27:0] keep their values.
- R2: In user mode (mode bits [4:0] = 10000), a full write to the current word changes only bits [31:28]. Bits [27:0] are unchanged.
- R3: In any other mode, a full write to the current word replaces all 32 bits with the source operand.
- R4: A saved-word access reaches the copy owned by the current mode. There are five separate copies, for FIQ=10001, IRQ=10010, supervisor=10011, abort=10111 and undefined=11011. Output `saved_status` shows the copy of the current mode.
- R5: A read returns the selected word unchanged on `rd_data` in the same cycle, combinationally. While no read is in progress, `rd_data` is zero.
- R6: In user mode (10000) and system mode (11111) there is no saved word. In those modes a saved-word write is ignored, and both a saved-word read and `saved_status` return zero.
- R7: A transfer whose register index `op_reg_idx` is 15 is rejected. Its write changes nothing, and its read returns zero.
- R8: A synchronous reset sets the current word to 0x000000D3 (supervisor mode with bits 7 and 6 set) and clears every saved word.
- R9: When `alu_flag_we` is high, `alu_flags` is loaded into bits [31:28] of the current word at the next rising edge, and bits [27:0] keep their values. A valid write to the current word in the same cycle wins, and the ALU flags are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes take effect at its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Transfer strobe |
| op_write | input | 1 | 1 = write a status word, 0 = read one |
| op_saved | input | 1 | 1 = saved word of the current mode, 0 = current word |
| op_flags_only | input | 1 | Write only bits [31:28] |
| op_reg_idx | input | 4 | General register index used as source or destination |
| src_data | input | 32 | Source operand (register or expanded immediate) |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_flags | input | 4 | N, Z, C, V from the ALU, MSB first |
| rd_data | output | 32 | Read data |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved word of the current mode, zero if none |
| cur_mode | output | 5 | Mode field of the current word |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, four flag bits, a 4-bit register index and the supervisor reset word. With these values every mode encoding and every bank can be reached from the data port alone, because a privileged full write can move the core into any mode.

The vector table walks the core through the following path:
- supervisor, IRQ, FIQ, system and finally user mode;
- in each mode it checks which saved copy is visible and which bits a write may change.

Once the core is in user mode, only reset can bring it out. Directed tests then reset it and cover three more cases:
- ALU flag updates, including their collision with a status write;
- the abort and undefined banks;
- a flags-only merge into a saved copy.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int MODE_W     = 5;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef struct packed {
        logic                  privileged;
        logic                  has_bank;
        logic [BANK_IDX_W-1:0] bank_idx;
    } mode_info_t;

    typedef struct packed {
        logic valid;
        logic write;
        logic saved;
        logic flags_only;
    } xfer_req_t;

    function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] m);
        mode_info_t info;
        info.privileged = (m != MODE_USR);
        info.has_bank   = 1'b1;
        info.bank_idx   = '0;
        case (m)
            MODE_FIQ: info.bank_idx = BANK_IDX_W'(0);
            MODE_IRQ: info.bank_idx = BANK_IDX_W'(1);
            MODE_SVC: info.bank_idx = BANK_IDX_W'(2);
            MODE_ABT: info.bank_idx = BANK_IDX_W'(3);
            MODE_UND: info.bank_idx = BANK_IDX_W'(4);
            default:  info.has_bank = 1'b0;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
    import psr_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_info_t        info
);
    always_comb info = decode_mode(mode);
endmodule

// File: rtl/psr_write_merge.sv
module psr_write_merge #(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 4
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] src_word,
    input  logic              flags_only,
    output logic [DATA_W-1:0] new_word
);
    localparam int LOW_W = DATA_W - FLAG_W;

    always_comb begin
        if (flags_only)
            new_word = {src_word[DATA_W-1 -: FLAG_W], old_word[LOW_W-1:0]};
        else
            new_word = src_word;
    end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
    import psr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  flags_only,
    input  logic [BANK_IDX_W-1:0] bank_idx,
    input  logic [DATA_W-1:0]     src_word,
    output logic [DATA_W-1:0]     rd_word
);
    logic [DATA_W-1:0] bank_q [NUM_BANKS];
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] merged;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (bank_idx == BANK_IDX_W'(i))
                sel_word = bank_q[i];
    end

    psr_write_merge #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) merge_i (
        .old_word   (sel_word),
        .src_word   (src_word),
        .flags_only (flags_only),
        .new_word   (merged)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[g] <= '0;
            else if (wr_en && bank_idx == BANK_IDX_W'(g))
                bank_q[g] <= merged;
        end
    end

    assign rd_word = sel_word;
endmodule

// File: rtl/status_xfer_unit.sv
module status_xfer_unit
    import psr_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              FLAG_W     = 4,
    parameter int              REG_IDX_W  = 4,
    parameter logic [31:0]     RESET_WORD = 32'h0000_00D3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic                 op_write,
    input  logic                 op_saved,
    input  logic                 op_flags_only,
    input  logic [REG_IDX_W-1:0] op_reg_idx,
    input  logic [DATA_W-1:0]    src_data,
    input  logic                 alu_flag_we,
    input  logic [FLAG_W-1:0]    alu_flags,
    output logic [DATA_W-1:0]    rd_data,
    output logic [DATA_W-1:0]    cur_status,
    output logic [DATA_W-1:0]    saved_status,
    output logic [MODE_W-1:0]    cur_mode
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;
    localparam int                   LOW_W  = DATA_W - FLAG_W;

    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] cur_merged;
    logic [DATA_W-1:0] bank_word;
    mode_info_t        info;
    xfer_req_t         req;
    logic              cur_wr;
    logic              sav_wr;

    always_comb begin
        req.valid      = op_valid && (op_reg_idx != PC_IDX);
        req.write      = op_write;
        req.saved      = op_saved;
        req.flags_only = op_flags_only;
    end

    psr_mode_decode mode_dec_i (
        .mode (cur_q[MODE_W-1:0]),
        .info (info)
    );

    assign cur_wr = req.valid && req.write && !req.saved;
    assign sav_wr = req.valid && req.write && req.saved && info.has_bank;

    psr_write_merge #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) cur_merge_i (
        .old_word   (cur_q),
        .src_word   (src_data),
        .flags_only (req.flags_only || !info.privileged),
        .new_word   (cur_merged)
    );

    psr_saved_bank #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (sav_wr),
        .flags_only (req.flags_only),
        .bank_idx   (info.bank_idx),
        .src_word   (src_data),
        .rd_word    (bank_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= RESET_WORD[DATA_W-1:0];
        else if (cur_wr)
            cur_q <= cur_merged;
        else if (alu_flag_we)
            cur_q <= {alu_flags, cur_q[LOW_W-1:0]};
    end

    always_comb begin
        saved_status = info.has_bank ? bank_word : '0;
        rd_data      = '0;
        if (req.valid && !req.write)
            rd_data = req.saved ? saved_status : cur_q;
    end

    assign cur_status = cur_q;
    assign cur_mode   = cur_q[MODE_W-1:0];
endmodule

// File: rtl/status_xfer_unit_chk.sv
module status_xfer_unit_chk
    import psr_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          FLAG_W     = 4,
    parameter int          REG_IDX_W  = 4,
    parameter logic [31:0] RESET_WORD = 32'h0000_00D3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 op_valid,
    input logic                 op_write,
    input logic                 op_saved,
    input logic                 op_flags_only,
    input logic [REG_IDX_W-1:0] op_reg_idx,
    input logic [DATA_W-1:0]    src_data,
    input logic                 alu_flag_we,
    input logic [FLAG_W-1:0]    alu_flags,
    input logic [DATA_W-1:0]    rd_data,
    input logic [DATA_W-1:0]    cur_status,
    input logic [DATA_W-1:0]    saved_status
);
    localparam int LOW_W = DATA_W - FLAG_W;

    logic ok_idx, in_user, no_bank, cur_write;
    assign ok_idx    = (op_reg_idx != '1);
    assign in_user   = (cur_status[MODE_W-1:0] == MODE_USR);
    assign no_bank   = in_user || (cur_status[MODE_W-1:0] == MODE_SYS);
    assign cur_write = op_valid && op_write && !op_saved && ok_idx;

    AST_RESET_WORD: assert property (@(posedge clk)
        rst |=> (cur_status == RESET_WORD[DATA_W-1:0]) && (saved_status == '0)); // R8

    AST_FLAGS_ONLY_CUR: assert property (@(posedge clk) disable iff (rst)
        (cur_write && op_flags_only) |=>
        (cur_status[LOW_W-1:0] == $past(cur_status[LOW_W-1:0])) &&
        (cur_status[DATA_W-1 -: FLAG_W] == $past(src_data[DATA_W-1 -: FLAG_W]))); // R1

    AST_USER_GUARD: assert property (@(posedge clk) disable iff (rst)
        (cur_write && in_user) |=>
        (cur_status[LOW_W-1:0] == $past(cur_status[LOW_W-1:0]))); // R2

    AST_PRIV_FULL: assert property (@(posedge clk) disable iff (rst)
        (cur_write && !op_flags_only && !in_user) |=> (cur_status == $past(src_data))); // R3

    AST_SAVED_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_write && op_saved && op_flags_only && ok_idx && !no_bank) |=>
        (saved_status[LOW_W-1:0] == $past(saved_status[LOW_W-1:0]))); // R4

    AST_READ_CUR: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_write && !op_saved && ok_idx) |-> (rd_data == cur_status)); // R5

    AST_NO_BANK: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_saved && no_bank) |-> (rd_data == '0) && (saved_status == '0)); // R6

    AST_PC_REJECT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !ok_idx && !alu_flag_we) |=>
        $stable(cur_status) && $stable(saved_status)); // R7

    AST_ALU_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (alu_flag_we && !cur_write) |=>
        (cur_status[DATA_W-1 -: FLAG_W] == $past(alu_flags)) &&
        (cur_status[LOW_W-1:0] == $past(cur_status[LOW_W-1:0]))); // R9
endmodule

bind status_xfer_unit status_xfer_unit_chk #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .REG_IDX_W(REG_IDX_W), .RESET_WORD(RESET_WORD)
) chk_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_write(op_write),
    .op_saved(op_saved), .op_flags_only(op_flags_only), .op_reg_idx(op_reg_idx),
    .src_data(src_data), .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
    .rd_data(rd_data), .cur_status(cur_status), .saved_status(saved_status)
);

// File: tb/status_xfer_unit_tb_top.sv
module status_xfer_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_write = 1'b0, op_saved = 1'b0, op_flags_only = 1'b0;
    logic [3:0]  op_reg_idx = 4'd0;
    logic [31:0] src_data = '0;
    logic        alu_flag_we = 1'b0;
    logic [3:0]  alu_flags = 4'd0;
    logic [31:0] rd_data, cur_status, saved_status;
    logic [4:0]  cur_mode;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd_seen;

    always #10 clk = ~clk;

    status_xfer_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_write(op_write),
        .op_saved(op_saved), .op_flags_only(op_flags_only), .op_reg_idx(op_reg_idx),
        .src_data(src_data), .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
        .rd_data(rd_data), .cur_status(cur_status), .saved_status(saved_status),
        .cur_mode(cur_mode)
    );

    typedef struct packed {
        logic        wr;
        logic        sv;
        logic        fl;
        logic [3:0]  rg;
        logic [31:0] src;
        logic [31:0] exp_cur;
        logic [31:0] exp_sav;
        logic [31:0] exp_rd;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,4'h1,32'h600000D3,32'h000000D3,32'h600000D3,32'h0,"R4"},
        '{1'b0,1'b1,1'b0,4'h2,32'h0,       32'h000000D3,32'h600000D3,32'h600000D3,"R5"},
        '{1'b1,1'b0,1'b1,4'h1,32'hA0000000,32'hA00000D3,32'h600000D3,32'h0,"R1"},
        '{1'b1,1'b0,1'b0,4'h1,32'h000000D2,32'h000000D2,32'h0,       32'h0,"R3"},
        '{1'b1,1'b1,1'b1,4'h1,32'hC0000000,32'h000000D2,32'hC0000000,32'h0,"R1"},
        '{1'b0,1'b0,1'b0,4'h3,32'h0,       32'h000000D2,32'hC0000000,32'h000000D2,"R5"},
        '{1'b1,1'b0,1'b0,4'h1,32'h000000D3,32'h000000D3,32'h600000D3,32'h0,"R4"},
        '{1'b1,1'b0,1'b0,4'h1,32'h00000011,32'h00000011,32'h0,       32'h0,"R4"},
        '{1'b1,1'b1,1'b0,4'h1,32'h12345678,32'h00000011,32'h12345678,32'h0,"R4"},
        '{1'b1,1'b0,1'b0,4'hF,32'hFFFFFFFF,32'h00000011,32'h12345678,32'h0,"R7"},
        '{1'b0,1'b1,1'b0,4'hF,32'h0,       32'h00000011,32'h12345678,32'h0,"R7"},
        '{1'b1,1'b0,1'b0,4'h1,32'h0000001F,32'h0000001F,32'h0,       32'h0,"R3"},
        '{1'b1,1'b1,1'b0,4'h1,32'hFFFFFFFF,32'h0000001F,32'h0,       32'h0,"R6"},
        '{1'b0,1'b1,1'b0,4'h1,32'h0,       32'h0000001F,32'h0,       32'h0,"R6"},
        '{1'b1,1'b0,1'b0,4'h1,32'h50000010,32'h50000010,32'h0,       32'h0,"R3"},
        '{1'b1,1'b0,1'b0,4'h1,32'h300000D3,32'h30000010,32'h0,       32'h0,"R2"},
        '{1'b1,1'b0,1'b1,4'h1,32'h9FFFFFFF,32'h90000010,32'h0,       32'h0,"R1"},
        '{1'b1,1'b1,1'b0,4'h1,32'hFFFFFFFF,32'h90000010,32'h0,       32'h0,"R6"},
        '{1'b0,1'b0,1'b0,4'h1,32'h0,       32'h90000010,32'h0,       32'h90000010,"R5"},
        '{1'b0,1'b1,1'b0,4'h1,32'h0,       32'h90000010,32'h0,       32'h0,"R6"}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, capture rd_data mid-cycle, let the rising edge
    // commit the write, then release the strobes.
    task automatic do_op(input logic w, input logic s, input logic f, input logic [3:0] rg,
                         input logic [31:0] src, input logic awe, input logic [3:0] af);
        @(negedge clk);
        op_valid = 1'b1; op_write = w; op_saved = s; op_flags_only = f;
        op_reg_idx = rg; src_data = src; alu_flag_we = awe; alu_flags = af;
        #2 rd_seen = rd_data;
        @(posedge clk);
        #2;
        op_valid = 1'b0; alu_flag_we = 1'b0;
    endtask

    task automatic alu_only(input logic [3:0] af);
        @(negedge clk);
        alu_flag_we = 1'b1; alu_flags = af;
        @(posedge clk);
        #2 alu_flag_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        check("R8 reset cur", cur_status, 32'h000000D3);
        check("R8 reset saved", saved_status, 32'h0);
        check("R5 idle rd", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].wr, VECS[i].sv, VECS[i].fl, VECS[i].rg, VECS[i].src, 1'b0, 4'h0);
            check($sformatf("%s vec%0d rd", VECS[i].tag, i), rd_seen, VECS[i].exp_rd);
            check($sformatf("%s vec%0d cur", VECS[i].tag, i), cur_status, VECS[i].exp_cur);
            check($sformatf("%s vec%0d saved", VECS[i].tag, i), saved_status, VECS[i].exp_sav);
        end

        // Reset out of user mode; all banks clear (R8)
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #2 rst = 1'b0;
        check("R8 re-reset cur", cur_status, 32'h000000D3);
        check("R8 re-reset saved", saved_status, 32'h0);

        // ALU flag port (R9)
        alu_only(4'h5);
        check("R9 alu flags", cur_status, 32'h500000D3);
        do_op(1'b1, 1'b0, 1'b1, 4'h2, 32'h20000000, 1'b1, 4'hF);
        check("R9 status write wins", cur_status, 32'h200000D3);

        // Abort and undefined banks are separate (R4)
        do_op(1'b1, 1'b0, 1'b0, 4'h1, 32'h000000D7, 1'b0, 4'h0);
        check("R4 abort mode", {27'd0, cur_mode}, 32'h17);
        do_op(1'b1, 1'b1, 1'b0, 4'h1, 32'hABCD0000, 1'b0, 4'h0);
        check("R4 abort saved", saved_status, 32'hABCD0000);
        do_op(1'b1, 1'b0, 1'b0, 4'h1, 32'h000000DB, 1'b0, 4'h0);
        check("R4 undef saved", saved_status, 32'h0);
        do_op(1'b1, 1'b0, 1'b0, 4'h1, 32'h000000D7, 1'b0, 4'h0);
        check("R4 abort saved kept", saved_status, 32'hABCD0000);

        // Flags-only merge into a saved copy (R1)
        do_op(1'b1, 1'b1, 1'b1, 4'h1, 32'h3000FFFF, 1'b0, 4'h0);
        check("R1 saved flags merge", saved_status, 32'h3BCD0000);
        do_op(1'b0, 1'b1, 1'b0, 4'h4, 32'h0, 1'b0, 4'h0);
        check("R5 saved read", rd_seen, 32'h3BCD0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule